// File: doc/BRIEF.md
# OTP In-System Programming Sequencer

This block lets firmware program and verify the one-time-programmable code store from inside the chip. Software loads a data byte and a 13-bit target address into registers. It then chooses an operation with a write-enable bit: a program pulse when the bit is set, a verify read when it is clear. The operation does not start on a register write. It starts when the core signals idle entry, and it ends in the cycle the timer wake-up arrives. After that the memory returns to normal code fetch.

An operation only starts when in-system mode is enabled and the external programming voltage is reported present. If a program pulse is requested without the voltage, a sticky error flag is raised. A signature-select bit steers accesses to the signature bytes. Reads from that space are allowed, but the block never drives a program pulse while it is set. A test-mode register sets the memory's DC read mode, and the block clears that register when software leaves in-system mode.

Top module: `otp_isp_seq`

## Requirements
- R1: After reset, every register reads 0x00 except the high-voltage status bit, which follows `hv_present`. `otp_prog`, `otp_vsense`, `otp_sig` and `otp_dc_read` are low.
- R2: Register 2 (address high) stores only bits [4:0] and reads back bits [7:5] as zero. Register 3 is the address low byte. `otp_addr` equals {addr_high[4:0], addr_low}.
- R3: With mode bits isp_en (bit 0) and wr_en (bit 1) set, sig_sel (bit 2) clear and `hv_present` high, a pulse on `idle_enter` raises `otp_prog` from the next cycle. `otp_prog` stays high until `timer_wake` is seen. While the pulse is high, `otp_wdata` carries the data register (register 1).
- R4: With isp_en set, wr_en clear and `hv_present` high, `idle_enter` raises `otp_vsense` from the next cycle. In the cycle `timer_wake` is high, `otp_rdata` is written into the data register, replacing any earlier value.
- R5: `idle_enter` starts no program or verify cycle unless isp_en is set and `hv_present` is high.
- R6: A program request (isp_en and wr_en set) on `idle_enter` while `hv_present` is low sets error bit 4 of the mode register. The bit stays set until the mode register (register 0) is written with bit 4 at one.
- R7: `otp_sig` follows sig_sel. While sig_sel is set, `idle_enter` with wr_en set drives no program pulse. Verify reads with sig_sel set are carried out normally.
- R8: `otp_prog` and `otp_vsense` are never high together. Both are low in any cycle in which `timer_wake` is high.
- R9: The test register (register 4) reads back what was written. `otp_dc_read` is high exactly when it holds 0x08. A mode write that clears isp_en while it was set forces the test register to 0x00.
- R10: An `idle_enter` pulse during a running program or verify cycle is ignored. The cycle keeps its kind and still ends on `timer_wake`.
- R11: Mode register bit 3 reads the live `hv_present` level, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| idle_enter | input | 1 | One-cycle strobe: the core entered idle |
| timer_wake | input | 1 | Timer interrupt that ends idle |
| hv_present | input | 1 | Programming high voltage detected |
| otp_addr | output | 13 | Memory address |
| otp_wdata | output | 8 | Memory program data |
| otp_rdata | input | 8 | Memory read data |
| otp_prog | output | 1 | Program pulse |
| otp_vsense | output | 1 | Verify sense-amplifier enable |
| otp_sig | output | 1 | Signature space select |
| otp_dc_read | output | 1 | DC read mode select |

## Verification
The bench first preloads the data register with 0xFF and then verifies a location that reads 0x00. A design that latches only changed bits, or that skips the latch, would leave 0xFF and hide a failed read. It requests a program pulse with the signature select set, and another with the voltage absent. A design that gates wrongly would pulse the memory, and a design whose error flag is not sticky or does not clear on write-one would be caught through the mode readback. It also strobes idle entry again during a running pulse and checks that both strobes drop in the wake cycle itself. A design that restarted, switched operation kind, or held the strobes for one more cycle would fail these checks.

// File: rtl/otp_isp_seq.sv
module otp_isp_seq #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          idle_enter,
  input  logic          timer_wake,
  input  logic          hv_present,
  output logic [AW-1:0] otp_addr,
  output logic [DW-1:0] otp_wdata,
  input  logic [DW-1:0] otp_rdata,
  output logic          otp_prog,
  output logic          otp_vsense,
  output logic          otp_sig,
  output logic          otp_dc_read
);
  localparam int HW = AW - 8;
  localparam logic [2:0] A_MODE = 3'd0, A_DATA = 3'd1, A_AHI = 3'd2,
                         A_ALO = 3'd3, A_TEST = 3'd4;
  localparam logic [DW-1:0] DCREAD = DW'(8'h08);

  typedef enum logic [1:0] {S_REST, S_PROG, S_VER} st_t;
  st_t st;

  logic          isp_en, wr_en, sig_sel, err;
  logic [DW-1:0] data_q, test_q;
  logic [HW-1:0] ahi_q;
  logic [7:0]    alo_q;

  wire wr_mode = reg_wr && reg_addr == A_MODE;
  wire armed   = isp_en && hv_present;
  wire go_prog = idle_enter && st == S_REST && armed && wr_en && !sig_sel;
  wire go_ver  = idle_enter && st == S_REST && armed && !wr_en;
  wire bad_hv  = idle_enter && st == S_REST && isp_en && wr_en && !hv_present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_REST;
    end else if (st != S_REST && timer_wake) begin
      st <= S_REST;
    end else if (go_prog) begin
      st <= S_PROG;
    end else if (go_ver) begin
      st <= S_VER;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isp_en  <= 1'b0;
      wr_en   <= 1'b0;
      sig_sel <= 1'b0;
      err     <= 1'b0;
      data_q  <= '0;
      ahi_q   <= '0;
      alo_q   <= '0;
      test_q  <= '0;
    end else begin
      if (wr_mode) begin
        isp_en  <= reg_wdata[0];
        wr_en   <= reg_wdata[1];
        sig_sel <= reg_wdata[2];
        if (reg_wdata[4]) err <= 1'b0;
        if (isp_en && !reg_wdata[0]) test_q <= '0;
      end
      if (bad_hv) err <= 1'b1;
      if (reg_wr && reg_addr == A_DATA) data_q <= reg_wdata;
      if (st == S_VER && timer_wake) data_q <= otp_rdata;
      if (reg_wr && reg_addr == A_AHI) ahi_q <= reg_wdata[HW-1:0];
      if (reg_wr && reg_addr == A_ALO) alo_q <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_TEST) test_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: reg_rdata = DW'({3'b000, err, hv_present, sig_sel, wr_en, isp_en});
      A_DATA: reg_rdata = data_q;
      A_AHI:  reg_rdata = DW'(ahi_q);
      A_ALO:  reg_rdata = DW'(alo_q);
      A_TEST: reg_rdata = test_q;
      default: reg_rdata = '0;
    endcase
  end

  assign otp_addr    = {ahi_q, alo_q};
  assign otp_wdata   = data_q;
  assign otp_prog    = st == S_PROG && !timer_wake;
  assign otp_vsense  = st == S_VER && !timer_wake;
  assign otp_sig     = sig_sel;
  assign otp_dc_read = test_q == DCREAD;
endmodule

module otp_isp_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       idle_enter,
  input logic       timer_wake,
  input logic       hv_present,
  input logic       otp_prog,
  input logic       otp_vsense,
  input logic       otp_sig,
  input logic       isp_en,
  input logic       wr_en,
  input logic       err
);
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(otp_prog && otp_vsense));

  p_wake_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_wake |-> !otp_prog && !otp_vsense);

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(otp_prog) || $rose(otp_vsense)) |-> $past(idle_enter && isp_en && hv_present));

  p_no_sig_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    otp_prog |-> !otp_sig);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(reg_wr && reg_addr == 3'd0 && reg_wdata[4])) |=> err);

  p_verify_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(otp_vsense) |-> $past(!wr_en));

  p_ahi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 3'd2 |-> reg_rdata[7:5] == 3'b000);

  p_hv_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 3'd0 |-> reg_rdata[3] == hv_present);
endmodule

bind otp_isp_seq otp_isp_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle_enter(idle_enter),
  .timer_wake(timer_wake), .hv_present(hv_present), .otp_prog(otp_prog),
  .otp_vsense(otp_vsense), .otp_sig(otp_sig), .isp_en(isp_en),
  .wr_en(wr_en), .err(err)
);

// File: tb/test_otp_isp_seq.sv
module test_otp_isp_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, otp_wdata, otp_rdata = '0;
  logic idle_enter = 1'b0, timer_wake = 1'b0, hv_present = 1'b0;
  logic [12:0] otp_addr;
  logic otp_prog, otp_vsense, otp_sig, otp_dc_read;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  otp_isp_seq i_otp_isp_seq (.*);

  // mode, hv, data, rdata, exp_prog, exp_vs, exp_data, exp_err
  localparam int NV = 8;
  localparam logic [35:0] VEC [NV] = '{
    {8'h03, 1'b1, 8'hA5, 8'h11, 1'b1, 1'b0, 8'hA5, 1'b0},
    {8'h01, 1'b1, 8'hFF, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0},
    {8'h01, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0},
    {8'h01, 1'b0, 8'hFF, 8'h12, 1'b0, 1'b0, 8'hFF, 1'b0},
    {8'h02, 1'b1, 8'h77, 8'h44, 1'b0, 1'b0, 8'h77, 1'b0},
    {8'h07, 1'b1, 8'h5A, 8'h66, 1'b0, 1'b0, 8'h5A, 1'b0},
    {8'h05, 1'b1, 8'hFF, 8'h9C, 1'b0, 1'b1, 8'h9C, 1'b0},
    {8'h03, 1'b0, 8'hC3, 8'h21, 1'b0, 1'b0, 8'hC3, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic idle_pulse();
    @(negedge clk); idle_enter = 1'b1;
    @(negedge clk); idle_enter = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 mode", 16'(v), 16'h00);
    rd(3'd1, v); chk("R1 data", 16'(v), 16'h00);
    rd(3'd4, v); chk("R1 test", 16'(v), 16'h00);
    chk("R1 strobes", 16'({otp_prog, otp_vsense, otp_sig, otp_dc_read}), 16'h0);
    hv_present = 1'b1; #1;
    rd(3'd0, v); chk("R11 hv status", 16'(v), 16'h08);

    // R9 test register, DC read
    wr(3'd4, 8'h08);
    rd(3'd4, v); chk("R9 test readback", 16'(v), 16'h08);
    chk("R9 dc_read", 16'(otp_dc_read), 16'h1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0] mw, dw, rdv, ed;
      logic hv, ep, ev, ee;
      {mw, hv, dw, rdv, ep, ev, ed, ee} = VEC[i];
      wr(3'd1, dw);
      wr(3'd0, mw | 8'h10);
      hv_present = hv; otp_rdata = rdv;
      idle_pulse();
      chk($sformatf("R3/R5/R7 prog v%0d", i), 16'(otp_prog), 16'(ep));
      chk($sformatf("R4/R5 vsense v%0d", i), 16'(otp_vsense), 16'(ev));
      chk($sformatf("R7 sig v%0d", i), 16'(otp_sig), 16'(mw[2]));
      if (ep) chk($sformatf("R3 wdata v%0d", i), 16'(otp_wdata), 16'(dw));
      repeat (2) @(negedge clk);
      timer_wake = 1'b1; #1;
      chk($sformatf("R8 drop v%0d", i), 16'({otp_prog, otp_vsense}), 16'h0);
      @(negedge clk); timer_wake = 1'b0; #1;
      chk($sformatf("R8 after v%0d", i), 16'({otp_prog, otp_vsense}), 16'h0);
      rd(3'd1, v); chk($sformatf("R4 data v%0d", i), 16'(v), 16'(ed));
      rd(3'd0, v); chk($sformatf("R6 err v%0d", i), 16'(v[4]), 16'(ee));
    end

    // R6 sticky across another op, then write-one clear
    hv_present = 1'b1;
    wr(3'd0, 8'h01);
    otp_rdata = 8'h55;
    idle_pulse();
    @(negedge clk); timer_wake = 1'b1; @(negedge clk); timer_wake = 1'b0;
    rd(3'd0, v); chk("R6 err still set", 16'(v[4]), 16'h1);
    wr(3'd0, 8'h11);
    rd(3'd0, v); chk("R6 err cleared", 16'(v[4]), 16'h0);

    // R11 bit 3 not writable
    hv_present = 1'b0;
    wr(3'd0, 8'h09); #1;
    rd(3'd0, v); chk("R11 hv write ignored", 16'(v), 16'h01);
    hv_present = 1'b1;

    // R2 address
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'h34);
    rd(3'd2, v); chk("R2 ahi readback", 16'(v), 16'h1F);
    chk("R2 otp_addr", 16'(otp_addr), 16'h1F34);

    // R10 idle during running pulse
    wr(3'd0, 8'h03);
    idle_pulse();
    chk("R10 prog start", 16'({otp_prog, otp_vsense}), 16'h2);
    wr(3'd0, 8'h01);
    idle_pulse();
    chk("R10 still prog", 16'({otp_prog, otp_vsense}), 16'h2);
    timer_wake = 1'b1; #1;
    chk("R10 ends on wake", 16'({otp_prog, otp_vsense}), 16'h0);
    @(negedge clk); timer_wake = 1'b0; #1;
    chk("R10 quiet after", 16'({otp_prog, otp_vsense}), 16'h0);

    // R9 leaving in-system mode clears test register
    wr(3'd4, 8'h08);
    wr(3'd0, 8'h00);
    rd(3'd4, v); chk("R9 test cleared", 16'(v), 16'h00);
    chk("R9 dc_read off", 16'(otp_dc_read), 16'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule